// File: doc/BRIEF.md
# Instruction Cache with Victim Swap

This block is a read-only instruction cache placed between a processor's memory bus and a slow, page-oriented flash store. A direct-mapped main array serves most fetches with no wait. Behind it sits a small, fully associative victim buffer that catches lines recently pushed out of the main array. The victim buffer is looked up only when the main array misses. On a victim hit the wanted line and the main-array line at that index trade places. On a miss in both, the displaced main-array line goes into the victim buffer and a whole line is fetched from flash.

The processor presents an address with a valid strobe and holds it until the cache answers with a one-cycle ready pulse that carries the read word. A fill toward flash is a level request with a line-aligned address. It stays raised until the flash side has delivered every word of the line as beats marked by a beat strobe. The flash latency may be long and may vary, and the beats may come with gaps. The cache returns the requested word as soon as its beat is stored. Any other request waits until the line is complete.

Top module: `icv_cache`

## Requirements
- R1: Reset (synchronous, active-low) clears every valid bit in both arrays and leaves `busy`, `fill_req` and `cpu_ready` low. The first fetch of any address after reset therefore causes a flash fill.
- R2: A fetch that hits the main array raises `cpu_ready` in the same cycle as `cpu_valid`, with no fill request.
- R3: The victim buffer is searched only after a main-array miss. On a victim hit the word is returned two cycles after the request with no flash fill, and the two lines swap places: the line that left the main array can later be fetched from the victim buffer, again without a fill.
- R4: On a miss in both arrays, `fill_addr` is the request address with its low log2(LINE_BYTES) bits cleared (LINE_BYTES = 256 by default). A valid line displaced from the main array goes into the victim buffer.
- R5: The victim buffer (VICT_LINES = 4 by default) replaces entries in first-in first-out order, so the line evicted from the main array longest ago is the one that is lost.
- R6: Fill beats carry consecutive words of the line, starting at word offset 0. `fill_beat` may have idle cycles between beats. `fill_req` and `fill_addr` stay constant until the last beat has been accepted.
- R7: During a fill, `cpu_ready` rises once for the missing request, in the cycle after the beat holding its word has been stored. If that word is the last one in the line, it is returned after the fill ends.
- R8: A request presented while a fill or a swap is in progress gets no `cpu_ready` until `busy` has dropped.
- R9: `busy` is high in every cycle in which a fill or a swap is in progress, and low otherwise.
- R10: `cpu_rdata` equals the flash word at the request address with the byte-select bits (`cpu_addr[1:0]` for 32-bit words) ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Fetch request, held until `cpu_ready` |
| cpu_addr | input | ADDR_W | Byte address of the fetch |
| cpu_ready | output | 1 | One-cycle pulse: `cpu_rdata` is valid |
| cpu_rdata | output | WORD_W | Fetched word |
| fill_req | output | 1 | Line fill request, held for the whole fill |
| fill_addr | output | ADDR_W | Line-aligned byte address of the fill |
| fill_beat | input | 1 | One word of the fill is on `fill_data` |
| fill_data | input | WORD_W | Fill word, in ascending offset order |
| busy | output | 1 | Fill or swap in progress |

## Verification
The bench builds the cache with a 10-bit address, 16-byte lines of four words, four main lines and two victim entries. With these values the whole 256-word address space can be swept in a scrambled order, and three or four lines that share one index are enough to exercise every swap and FIFO eviction. A reference model of tags, valid bits and FIFO order predicts hit, swap or fill for each fetch. The flash model varies both its latency and the gaps between beats, so requested words at every line offset come back both before and after the fill ends.

// File: rtl/icv_pkg.sv
// Shared types for the instruction cache with victim swap.
package icv_pkg;

    // Controller states: lookup, one-cycle line swap, flash line fill.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SWAP = 2'd1,
        ST_FILL = 2'd2
    } icv_state_e;

endpackage

// File: rtl/icv_main_array.sv
// Direct-mapped main array: one tag, valid bit and line of data per index.
// Assumes a single index is addressed per cycle. Reads are combinational.
// Writes to tag/valid, a whole line, or one word take effect at the clock
// edge. Only the valid bits are reset.
module icv_main_array #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 64,
    parameter int MAIN_LINES = 16,
    parameter int TAG_W      = 20,
    localparam int IDX_W  = $clog2(MAIN_LINES),
    localparam int OFF_W  = $clog2(LINE_WORDS),
    localparam int LINE_W = LINE_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_word,
    output logic [LINE_W-1:0] rd_line,
    input  logic              meta_we,
    input  logic [TAG_W-1:0]  meta_tag,
    input  logic              meta_valid,
    input  logic              line_we,
    input  logic [LINE_W-1:0] line_data,
    input  logic              word_we,
    input  logic [OFF_W-1:0]  word_off,
    input  logic [WORD_W-1:0] word_data
);

    logic [TAG_W-1:0]  tag_q   [MAIN_LINES];
    logic [LINE_W-1:0] data_q  [MAIN_LINES];
    logic [MAIN_LINES-1:0] valid_q;

    // Combinational read of the addressed entry.
    always_comb begin
        rd_tag   = tag_q[idx];
        rd_valid = valid_q[idx];
        rd_line  = data_q[idx];
        rd_word  = data_q[idx][rd_off*WORD_W +: WORD_W];
    end

    // Valid bits: cleared by reset, updated by metadata writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (meta_we) begin
            valid_q[idx] <= meta_valid;
        end
    end

    // Tags: written together with the valid bit.
    always_ff @(posedge clk) begin
        if (meta_we) begin
            tag_q[idx] <= meta_tag;
        end
    end

    // Line data: loaded whole on a swap, word by word during a fill.
    always_ff @(posedge clk) begin
        if (line_we) begin
            data_q[idx] <= line_data;
        end else if (word_we) begin
            data_q[idx][word_off*WORD_W +: WORD_W] <= word_data;
        end
    end

endmodule

// File: rtl/icv_victim_buf.sv
// Fully associative victim buffer with first-in first-out replacement.
// Each entry keeps a full line address, a valid bit and a line of data.
// Assumes VICT_LINES >= 2 and that a line address is never held twice.
// A push writes at the FIFO pointer and advances it. A put rewrites a given
// slot (used by the swap) and leaves the pointer where it is.
module icv_victim_buf #(
    parameter int VICT_LINES = 4,
    parameter int LA_W       = 24,
    parameter int LINE_W     = 2048,
    localparam int VW = (VICT_LINES > 1) ? $clog2(VICT_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LA_W-1:0]   look_la,
    output logic              hit,
    output logic [VW-1:0]     hit_slot,
    output logic [LINE_W-1:0] hit_line,
    input  logic              push_en,
    input  logic              put_en,
    input  logic [VW-1:0]     put_slot,
    input  logic              put_valid,
    input  logic [LA_W-1:0]   wr_la,
    input  logic [LINE_W-1:0] wr_line
);

    logic [LA_W-1:0]       la_q   [VICT_LINES];
    logic [LINE_W-1:0]     line_q [VICT_LINES];
    logic [VICT_LINES-1:0] valid_q;
    logic [VICT_LINES-1:0] match;
    logic [VW-1:0]         ptr_q;
    logic [VW-1:0]         wr_slot;

    // One comparator per entry.
    for (genvar g = 0; g < VICT_LINES; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (la_q[g] == look_la);
    end

    // Encode the matching entry and select its line.
    always_comb begin
        hit_slot = '0;
        for (int i = 0; i < VICT_LINES; i++) begin
            if (match[i]) hit_slot = VW'(i);
        end
        hit      = |match;
        hit_line = line_q[hit_slot];
    end

    // Write slot: FIFO pointer for a push, given slot for a put.
    assign wr_slot = push_en ? ptr_q : put_slot;

    // Valid bits and FIFO pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (push_en) begin
            valid_q[wr_slot] <= 1'b1;
            ptr_q <= (ptr_q == VW'(VICT_LINES - 1)) ? '0 : ptr_q + 1'b1;
        end else if (put_en) begin
            valid_q[wr_slot] <= put_valid;
        end
    end

    // Line addresses and data of the written slot.
    always_ff @(posedge clk) begin
        if (push_en || put_en) begin
            la_q[wr_slot]   <= wr_la;
            line_q[wr_slot] <= wr_line;
        end
    end

endmodule

// File: rtl/icv_cache.sv
// Read-only instruction cache: a direct-mapped main array backed by a
// fully associative victim buffer, filled from a slow line-oriented store.
// Assumes the processor holds cpu_valid/cpu_addr until cpu_ready, and the
// store delivers exactly LINE_WORDS beats in offset order per fill_req.
// A victim hit swaps lines in one extra cycle. A full miss moves the main
// line into the victim FIFO, then streams the new line in.
module icv_cache
    import icv_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_BYTES = 256,
    parameter int MAIN_LINES = 16,
    parameter int VICT_LINES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_beat,
    input  logic [WORD_W-1:0] fill_data,
    output logic              busy
);

    localparam int WORD_BYTES = WORD_W / 8;
    localparam int BOFF_W     = $clog2(WORD_BYTES);
    localparam int LINE_WORDS = LINE_BYTES / WORD_BYTES;
    localparam int OFF_W      = $clog2(LINE_WORDS);
    localparam int IDX_W      = $clog2(MAIN_LINES);
    localparam int LA_W       = ADDR_W - OFF_W - BOFF_W;
    localparam int TAG_W      = LA_W - IDX_W;
    localparam int LINE_W     = LINE_WORDS * WORD_W;
    localparam int VW         = (VICT_LINES > 1) ? $clog2(VICT_LINES) : 1;
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_WORDS - 1);

    icv_state_e        state_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [OFF_W-1:0]  beat_q;
    logic              served_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [LA_W-1:0]   cur_la;
    logic [TAG_W-1:0]  cur_tag;
    logic [IDX_W-1:0]  cur_idx;
    logic [OFF_W-1:0]  cur_off;

    logic [TAG_W-1:0]  m_tag;
    logic              m_valid;
    logic              m_hit;
    logic [WORD_W-1:0] m_word;
    logic [LINE_W-1:0] m_line;
    logic              meta_we;
    logic [TAG_W-1:0]  meta_tag;
    logic              meta_valid;
    logic              line_we;
    logic              word_we;

    logic              v_hit;
    logic [VW-1:0]     v_slot;
    logic [LINE_W-1:0] v_line;
    logic              push_en;
    logic              put_en;
    logic              put_valid;
    logic [LA_W-1:0]   wr_la;

    logic              unused_byte_sel;

    // Lookup address: the live request when idle, the held one otherwise.
    always_comb begin
        cur_addr = (state_q == ST_IDLE) ? cpu_addr : req_addr_q;
        cur_la   = cur_addr[ADDR_W-1 -: LA_W];
        cur_tag  = cur_la[LA_W-1 -: TAG_W];
        cur_idx  = cur_la[IDX_W-1:0];
        cur_off  = cur_addr[BOFF_W +: OFF_W];
    end

    assign unused_byte_sel = ^{cpu_addr[BOFF_W-1:0], req_addr_q[BOFF_W-1:0]};

    icv_main_array #(
        .WORD_W    (WORD_W),
        .LINE_WORDS(LINE_WORDS),
        .MAIN_LINES(MAIN_LINES),
        .TAG_W     (TAG_W)
    ) u_main (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (cur_idx),
        .rd_off    (cur_off),
        .rd_tag    (m_tag),
        .rd_valid  (m_valid),
        .rd_word   (m_word),
        .rd_line   (m_line),
        .meta_we   (meta_we),
        .meta_tag  (meta_tag),
        .meta_valid(meta_valid),
        .line_we   (line_we),
        .line_data (v_line),
        .word_we   (word_we),
        .word_off  (beat_q),
        .word_data (fill_data)
    );

    icv_victim_buf #(
        .VICT_LINES(VICT_LINES),
        .LA_W      (LA_W),
        .LINE_W    (LINE_W)
    ) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_la  (cur_la),
        .hit      (v_hit),
        .hit_slot (v_slot),
        .hit_line (v_line),
        .push_en  (push_en),
        .put_en   (put_en),
        .put_slot (v_slot),
        .put_valid(put_valid),
        .wr_la    (wr_la),
        .wr_line  (m_line)
    );

    assign m_hit     = m_valid && (m_tag == cur_tag);
    assign wr_la     = {m_tag, cur_idx};
    assign cpu_rdata = m_word;
    assign busy      = (state_q != ST_IDLE);
    assign fill_req  = (state_q == ST_FILL);
    assign fill_addr = {req_addr_q[ADDR_W-1 -: LA_W], {(OFF_W + BOFF_W){1'b0}}};

    // Per-state strobes for the arrays and the processor handshake.
    always_comb begin
        cpu_ready  = 1'b0;
        meta_we    = 1'b0;
        meta_tag   = cur_tag;
        meta_valid = 1'b0;
        line_we    = 1'b0;
        word_we    = 1'b0;
        push_en    = 1'b0;
        put_en     = 1'b0;
        put_valid  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cpu_valid) begin
                    if (m_hit) begin
                        cpu_ready = 1'b1;
                    end else if (!v_hit) begin
                        push_en = m_valid;
                        meta_we = 1'b1;
                    end
                end
            end
            ST_SWAP: begin
                line_we    = 1'b1;
                meta_we    = 1'b1;
                meta_valid = 1'b1;
                put_en     = 1'b1;
                put_valid  = m_valid;
            end
            ST_FILL: begin
                word_we   = fill_beat;
                cpu_ready = cpu_valid && !served_q && (cur_off < beat_q);
                if (fill_beat && (beat_q == LAST_OFF)) begin
                    meta_we    = 1'b1;
                    meta_valid = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Controller state, held request, beat counter and served flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            req_addr_q <= '0;
            beat_q     <= '0;
            served_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cpu_valid && !m_hit) begin
                        req_addr_q <= cpu_addr;
                        beat_q     <= '0;
                        served_q   <= 1'b0;
                        state_q    <= v_hit ? ST_SWAP : ST_FILL;
                    end
                end
                ST_SWAP: begin
                    state_q <= ST_IDLE;
                end
                ST_FILL: begin
                    if (cpu_ready) served_q <= 1'b1;
                    if (fill_beat) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == LAST_OFF) state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/icv_cache_checker.sv
// Protocol checker for icv_cache, attached by bind. Observes ports only.
module icv_cache_checker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 256,
    localparam int ALIGN_W = $clog2(LINE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic              cpu_ready,
    input logic              busy,
    input logic              fill_req,
    input logic              fill_beat,
    input logic [ADDR_W-1:0] fill_addr
);

    // After reset is released the cache starts idle.
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !fill_req));

    // Fill addresses are line aligned.
    assert_fill_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> (fill_addr[ALIGN_W-1:0] == '0));

    // The fill address does not move while the request is up.
    assert_fill_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && $past(fill_req)) |-> $stable(fill_addr));

    // Beats are only accepted against an open request.
    assert_beat_in_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_beat |-> fill_req);

    // Ready is only given to a presented request.
    assert_ready_has_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_valid);

    // Only one early answer per fill.
    assert_single_early_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && fill_req) |=> !(cpu_ready && fill_req));

    // A fill always shows as busy.
    assert_busy_in_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> busy);

endmodule

bind icv_cache icv_cache_checker #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES)
) u_icv_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_valid(cpu_valid),
    .cpu_ready(cpu_ready),
    .busy     (busy),
    .fill_req (fill_req),
    .fill_beat(fill_beat),
    .fill_addr(fill_addr)
);

// File: tb/icv_cache_test.sv
`timescale 1ns/1ps
module icv_cache_test;

    localparam int ADDR_W     = 10;
    localparam int WORD_W     = 32;
    localparam int LINE_BYTES = 16;
    localparam int MAIN_LINES = 4;
    localparam int VICT_LINES = 2;
    localparam int LINE_WORDS = LINE_BYTES / 4;
    localparam int N_WORDS    = (1 << ADDR_W) / 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_valid = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic              cpu_ready;
    logic [WORD_W-1:0] cpu_rdata;
    logic              fill_req;
    logic [ADDR_W-1:0] fill_addr;
    logic              fill_beat = 1'b0;
    logic [WORD_W-1:0] fill_data = '0;
    logic              busy;

    int n_chk = 0;
    int n_fail = 0;
    int n_fill = 0;
    int cycles = 0;
    logic [ADDR_W-1:0] last_fill;

    // Reference model of cache contents (line addresses).
    logic [5:0] ref_m_la [MAIN_LINES];
    bit         ref_m_v  [MAIN_LINES];
    logic [5:0] ref_v_la [VICT_LINES];
    bit         ref_v_v  [VICT_LINES];
    int         ref_ptr;

    always #2 clk = ~clk;

    icv_cache #(
        .ADDR_W    (ADDR_W),
        .WORD_W    (WORD_W),
        .LINE_BYTES(LINE_BYTES),
        .MAIN_LINES(MAIN_LINES),
        .VICT_LINES(VICT_LINES)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_valid(cpu_valid),
        .cpu_addr (cpu_addr),
        .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata),
        .fill_req (fill_req),
        .fill_addr(fill_addr),
        .fill_beat(fill_beat),
        .fill_data(fill_data),
        .busy     (busy)
    );

    function automatic logic [WORD_W-1:0] store_word(input logic [ADDR_W-1:0] a);
        logic [WORD_W-1:0] w;
        w = WORD_W'({a[ADDR_W-1:2], 2'b00});
        return w * 32'h9E37_79B1 + 32'h0BAD_F00D;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < MAIN_LINES; i++) ref_m_v[i] = 0;
        for (int i = 0; i < VICT_LINES; i++) ref_v_v[i] = 0;
        ref_ptr = 0;
    endtask

    // Flash model: variable latency, gaps between beats.
    initial begin
        forever begin
            @(negedge clk);
            if (fill_req) begin
                logic [ADDR_W-1:0] fa;
                fa = fill_addr;
                last_fill = fa;
                n_fill++;
                chk(fa[3:0] == 4'h0, "R4 fill alignment", 32'(fa), 32'(fa & ~10'hF));
                repeat (2 + (n_fill % 7)) @(negedge clk);
                for (int b = 0; b < LINE_WORDS; b++) begin
                    if (((b + n_fill) % 3) == 0) begin
                        fill_beat = 1'b0;
                        @(negedge clk);
                    end
                    fill_beat = 1'b1;
                    fill_data = store_word(fa + ADDR_W'(4 * b));
                    @(negedge clk);
                end
                fill_beat = 1'b0;
            end
        end
    end

    // One fetch, classified and checked against the reference model.
    task automatic access(input logic [ADDR_W-1:0] a);
        logic [5:0] la;
        logic [1:0] idx;
        logic [1:0] off;
        int kind;
        int slot;
        int cyc;
        int f0;
        bit busy0;
        bit busy_at;
        logic [WORD_W-1:0] got;
        la = a[9:4];
        idx = la[1:0];
        off = a[3:2];
        slot = 0;
        if (ref_m_v[idx] && ref_m_la[idx] == la) kind = 0;
        else begin
            kind = 2;
            for (int i = 0; i < VICT_LINES; i++)
                if (ref_v_v[i] && ref_v_la[i] == la) begin kind = 1; slot = i; end
        end
        @(negedge clk);
        cpu_valid = 1'b1;
        cpu_addr = a;
        f0 = n_fill;
        #0.5;
        busy0 = busy;
        cyc = 0;
        while (!cpu_ready && cyc < 2000) begin
            @(negedge clk);
            #0.5;
            cyc++;
        end
        got = cpu_rdata;
        busy_at = busy;
        chk(cpu_ready == 1'b1, "R7 request answered", 32'(cpu_ready), 32'd1);
        chk(got == store_word(a), "R10 read data", got, store_word(a));
        if (kind == 0) begin
            chk(n_fill == f0, "R2 hit makes no fill", 32'(n_fill), 32'(f0));
            if (!busy0) chk(cyc == 0, "R2 hit latency", 32'(cyc), 32'd0);
            chk(!busy_at, "R8 held until idle", 32'(busy_at), 32'd0);
        end else if (kind == 1) begin
            chk(n_fill == f0, "R3 victim hit makes no fill", 32'(n_fill), 32'(f0));
            if (!busy0) chk(cyc == 2, "R3 victim latency", 32'(cyc), 32'd2);
            chk(!busy_at, "R8 held until idle", 32'(busy_at), 32'd0);
        end else begin
            chk(n_fill == f0 + 1, "R4 miss makes one fill", 32'(n_fill), 32'(f0 + 1));
            chk(last_fill == {la, 4'h0}, "R4 fill address", 32'(last_fill), 32'({la, 4'h0}));
            chk(busy_at == (off != 2'd3), "R7 early word return", 32'(busy_at), 32'(off != 2'd3));
        end
        @(negedge clk);
        cpu_valid = 1'b0;
        if (kind == 1) begin
            logic [5:0] t_la;
            bit t_v;
            t_la = ref_m_la[idx];
            t_v = ref_m_v[idx];
            ref_m_la[idx] = la;
            ref_m_v[idx] = 1;
            ref_v_la[slot] = t_la;
            ref_v_v[slot] = t_v;
        end else if (kind == 2) begin
            if (ref_m_v[idx]) begin
                ref_v_la[ref_ptr] = ref_m_la[idx];
                ref_v_v[ref_ptr] = 1;
                ref_ptr = (ref_ptr + 1) % VICT_LINES;
            end
            ref_m_la[idx] = la;
            ref_m_v[idx] = 1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cpu_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        #0.5;
        chk(!busy && !fill_req && !cpu_ready, "R1 idle after reset",
            32'({busy, fill_req, cpu_ready}), 32'd0);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();

        // R1: first fetch after reset misses; then sequential sweep (R6, R7).
        for (int w = 0; w < 64; w++) access(ADDR_W'(w * 4));

        // R3: three lines on one index fit main + victim, so they swap.
        for (int r = 0; r < 12; r++) access(ADDR_W'(((1 + 4 * (r % 3)) << 4) + ((r % 4) << 2)));

        // R5: four lines on one index overflow the FIFO and refill.
        for (int r = 0; r < 12; r++) access(ADDR_W'(((2 + 4 * (r % 4)) << 4) + ((r % 4) << 2)));

        // R10: every word of the space, scrambled order, with byte bits set.
        for (int i = 0; i < N_WORDS; i++)
            access(ADDR_W'((((i * 37 + 11) % N_WORDS) << 2) | (i % 4)));

        // R1: reset drops cached lines; refetch misses then hits.
        do_reset();
        access(ADDR_W'(12));
        access(ADDR_W'(12));
        access(ADDR_W'(4));

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule